// File: doc/BRIEF.md
# Clock-Recovery Lock Acquisition Controller

This block supervises a clock-recovery loop. After reset it keeps the loop on the local reference. Once the reference has been held, it hands the loop over to the incoming serial data. Frequency is judged by counting edges of a prescaled copy of the recovered clock across a fixed window of reference cycles. The count is compared with an acceptance band worked out at elaboration from the window length, the prescaler, the selected rate ratio and a ±500 ppm tolerance.

Loss of signal can come from two sources. One is the external flag from the optical module, passed through a two-flop synchronizer. The other is an internal detector that watches the sampled serial line for transitions. While either is active, the loop is held on the reference and every parallel receive word that is accepted is replaced with zeros. The block runs entirely on the reference clock, so received words keep flowing downstream while lock or signal is lost. A bypass input takes the supervisor out of the loop and passes an externally recovered word bus through to the output.

Top module: `cdr_acq_top`

## Requirements
- R1: After reset `trackData` stays low until one full measurement window taken while on the reference has fallen inside the acceptance band. A second in-band window must follow before `trackData` rises, about two windows after reset.
- R2: `lockStatus` is high only while locked to data. It rises only after two consecutive in-band windows measured while `trackData` is high, about two windows after `trackData` rises.
- R3: While `trackData` is high, a single out-of-band window drives `trackData` and `lockStatus` low on the following cycle.
- R4: A parallel word accepted while the synchronized external loss input or the internal loss flag is active appears on `rxWordOut` as all zeros. The external input reaches the mute within three clock edges, and the mute releases within three edges of the loss clearing.
- R5: Any loss of signal drops `trackData` and `lockStatus`. Data tracking resumes only after the loss has cleared and a following window on the reference has been measured in-band.
- R6: Internal loss of signal is declared after `LOS_QUIET` reference cycles with no change on `serialSample`. It is cleared after `LOS_CLR_SEGS` consecutive segments of `LOS_QUIET` cycles in which each segment contains a change.
- R7: The expected edge count per window is WINDOW·ratio/PRESCALE. The ratio depends on the reference and the output rate: 2 for a 77.76 MHz reference at 155.52 MHz, 8 for 77.76 MHz at 622.08 MHz, 8 for 19.44 MHz at 155.52 MHz, and 32 for 19.44 MHz at 622.08 MHz. `rateSel`=1 selects 622.08 MHz. `refFreqSel`=1 selects a 77.76 MHz shared reference. `auxRefSel`=1 forces a 77.76 MHz reference.
- R8: The acceptance band is the expected count ± max(ceil(expected·PPM_TOL/10^6), MIN_TOL). An error inside the band keeps lock.
- R9: While `bypassEn` is high, `trackData` and `lockStatus` are low and accepted words come from `bypWordIn`. Releasing bypass restarts acquisition from the reference.
- R10: `rxWordOutValid` repeats `rxWordValid` one cycle later in every state, including during loss of signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock; clocks all logic |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 1 | 1 = 622.08 MHz recovered rate, 0 = 155.52 MHz |
| refFreqSel | input | 1 | 1 = shared reference is 77.76 MHz, 0 = 19.44 MHz |
| auxRefSel | input | 1 | 1 = auxiliary 77.76 MHz reference in use |
| bypassEn | input | 1 | Disables steering and selects the bypass word bus |
| extLosIn | input | 1 | Asynchronous loss-of-signal flag from the optical module |
| recDivClk | input | 1 | Recovered clock divided by PRESCALE, asynchronous |
| serialSample | input | 1 | Sampled serial line, used for transition detection |
| rxWordIn | input | WORD_W | Parallel word from the deserializer |
| rxWordValid | input | 1 | Strobe for rxWordIn and bypWordIn |
| bypWordIn | input | WORD_W | Word recovered with an external clock |
| trackData | output | 1 | 1 = loop steered to data, 0 = to the reference |
| lockStatus | output | 1 | High while locked to the data stream |
| rxWordOut | output | WORD_W | Registered receive word, zero while muted |
| rxWordOutValid | output | 1 | Strobe for rxWordOut |

## Verification
Most faults in the state register or the good-window flag show up at the ports through the timing of `trackData` and `lockStatus`. A skipped stage moves a rising edge about one window early, and a missed fallback leaves `lockStatus` high for a window or more after the frequency is pulled out of band. A wrong acceptance band or a wrong rate ratio means lock is never reached within a few windows. A fault in the loss logic is visible within a handful of cycles as a nonzero word while loss is active, or as a lock bit that does not fall. The internal detector's thresholds show up a few dozen cycles either side of the expected point.

// File: rtl/cdr_acq_pkg.sv
`timescale 1ns/1ps
package cdr_acq_pkg;

  typedef enum logic [2:0] {
    ST_RESET       = 3'd0,
    ST_REF_ACQ     = 3'd1,
    ST_REF_LOCKED  = 3'd2,
    ST_DATA_ACQ    = 3'd3,
    ST_DATA_LOCKED = 3'd4,
    ST_LOS_HOLD    = 3'd5
  } acq_state_t;

  // strobes from the control FSM to the measurement/data path
  typedef struct packed {
    logic winRestart;
    logic muteEn;
    logic selBypass;
  } acq_strobe_t;

endpackage

// File: rtl/cdr_acq_datapath.sv
`timescale 1ns/1ps
module cdr_acq_datapath
  import cdr_acq_pkg::*;
#(
  parameter int unsigned WINDOW       = 65536,
  parameter int unsigned PRESCALE     = 128,
  parameter int unsigned PPM_TOL      = 500,
  parameter int unsigned MIN_TOL      = 2,
  parameter int unsigned LOS_QUIET    = 256,
  parameter int unsigned LOS_CLR_SEGS = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned WORD_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateSel,
  input  logic              refFreqSel,
  input  logic              auxRefSel,
  input  logic              recDivClk,
  input  logic              extLosIn,
  input  logic              serialSample,
  input  logic [WORD_W-1:0] rxWordIn,
  input  logic              rxWordValid,
  input  logic [WORD_W-1:0] bypWordIn,
  input  acq_strobe_t       strobe,
  output logic              windowDone,
  output logic              inWindow,
  output logic              losAny,
  output logic [WORD_W-1:0] rxWordOut,
  output logic              rxWordOutValid
);

  localparam int unsigned WIN_W = $clog2(WINDOW);
  localparam int unsigned CNT_W = $clog2(WINDOW + 1) + 1;
  localparam int unsigned QW    = $clog2(LOS_QUIET + 1);
  localparam int unsigned GW    = $clog2(LOS_CLR_SEGS + 1);

  function automatic int unsigned tolOf(input int unsigned e);
    int unsigned t;
    t = (e * PPM_TOL + 999999) / 1000000;
    return (t < MIN_TOL) ? MIN_TOL : t;
  endfunction

  localparam int unsigned EXP_2  = WINDOW * 2 / PRESCALE;
  localparam int unsigned EXP_8  = WINDOW * 8 / PRESCALE;
  localparam int unsigned EXP_32 = WINDOW * 32 / PRESCALE;
  localparam int unsigned TOL_2  = tolOf(EXP_2);
  localparam int unsigned TOL_8  = tolOf(EXP_8);
  localparam int unsigned TOL_32 = tolOf(EXP_32);
  localparam int unsigned LO_2   = (EXP_2 > TOL_2) ? EXP_2 - TOL_2 : 0;
  localparam int unsigned LO_8   = (EXP_8 > TOL_8) ? EXP_8 - TOL_8 : 0;
  localparam int unsigned LO_32  = (EXP_32 > TOL_32) ? EXP_32 - TOL_32 : 0;
  localparam int unsigned HI_2   = EXP_2 + TOL_2;
  localparam int unsigned HI_8   = EXP_8 + TOL_8;
  localparam int unsigned HI_32  = EXP_32 + TOL_32;

  // ---------------- synchronizers ----------------
  logic [SYNC_STAGES:0]   recPipe;
  logic [SYNC_STAGES-1:0] extPipe;
  logic                   recTick;
  logic                   extLosSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recPipe <= '0;
      extPipe <= '0;
    end else begin
      recPipe <= {recPipe[SYNC_STAGES-1:0], recDivClk};
      extPipe <= {extPipe[SYNC_STAGES-2:0], extLosIn};
    end
  end

  assign recTick    = recPipe[SYNC_STAGES-1] & ~recPipe[SYNC_STAGES];
  assign extLosSync = extPipe[SYNC_STAGES-1];

  // ---------------- frequency window ----------------
  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] measCnt;
  logic [CNT_W-1:0] loB;
  logic [CNT_W-1:0] hiB;
  logic             ref77;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt     <= '0;
      edgeCnt    <= '0;
      measCnt    <= '0;
      windowDone <= 1'b0;
    end else if (strobe.winRestart) begin
      winCnt     <= '0;
      edgeCnt    <= '0;
      windowDone <= 1'b0;
    end else if (winCnt == WIN_W'(WINDOW - 1)) begin
      winCnt     <= '0;
      measCnt    <= edgeCnt + CNT_W'(recTick);
      edgeCnt    <= '0;
      windowDone <= 1'b1;
    end else begin
      winCnt     <= winCnt + 1'b1;
      edgeCnt    <= edgeCnt + CNT_W'(recTick);
      windowDone <= 1'b0;
    end
  end

  assign ref77 = refFreqSel | auxRefSel;

  always_comb begin
    case ({ref77, rateSel})
      2'b10:   begin loB = CNT_W'(LO_2);  hiB = CNT_W'(HI_2);  end
      2'b01:   begin loB = CNT_W'(LO_32); hiB = CNT_W'(HI_32); end
      default: begin loB = CNT_W'(LO_8);  hiB = CNT_W'(HI_8);  end
    endcase
  end

  assign inWindow = (measCnt >= loB) && (measCnt <= hiB);

  // ---------------- internal loss-of-signal ----------------
  logic          serPrev;
  logic          trans;
  logic          losInt;
  logic [QW-1:0] quietCnt;
  logic [QW-1:0] segCnt;
  logic          segEdge;
  logic [GW-1:0] goodSegs;

  assign trans = serialSample ^ serPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serPrev  <= 1'b0;
      losInt   <= 1'b0;
      quietCnt <= '0;
      segCnt   <= '0;
      segEdge  <= 1'b0;
      goodSegs <= '0;
    end else begin
      serPrev <= serialSample;
      if (!losInt) begin
        if (trans) begin
          quietCnt <= '0;
        end else if (quietCnt == QW'(LOS_QUIET - 1)) begin
          losInt   <= 1'b1;
          segCnt   <= '0;
          segEdge  <= 1'b0;
          goodSegs <= '0;
        end else begin
          quietCnt <= quietCnt + 1'b1;
        end
      end else if (segCnt == QW'(LOS_QUIET - 1)) begin
        segCnt  <= '0;
        segEdge <= 1'b0;
        if (segEdge | trans) begin
          if (goodSegs == GW'(LOS_CLR_SEGS - 1)) begin
            losInt   <= 1'b0;
            quietCnt <= '0;
            goodSegs <= '0;
          end else begin
            goodSegs <= goodSegs + 1'b1;
          end
        end else begin
          goodSegs <= '0;
        end
      end else begin
        segCnt  <= segCnt + 1'b1;
        segEdge <= segEdge | trans;
      end
    end
  end

  assign losAny = losInt | extLosSync;

  // ---------------- receive word path ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWordOut      <= '0;
      rxWordOutValid <= 1'b0;
    end else begin
      rxWordOutValid <= rxWordValid;
      if (rxWordValid) begin
        if (strobe.muteEn)         rxWordOut <= '0;
        else if (strobe.selBypass) rxWordOut <= bypWordIn;
        else                       rxWordOut <= rxWordIn;
      end
    end
  end

  // R4
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxWordValid && strobe.muteEn) |=> (rxWordOut == '0));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxWordValid |=> rxWordOutValid);

  // R6
  transition_no_los_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trans && !losInt) |=> !losInt);

endmodule

// File: rtl/cdr_acq_ctrl.sv
`timescale 1ns/1ps
module cdr_acq_ctrl
  import cdr_acq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bypassEn,
  input  logic        windowDone,
  input  logic        inWindow,
  input  logic        losAny,
  output acq_strobe_t strobe,
  output logic        trackData,
  output logic        lockStatus
);

  acq_state_t state;
  acq_state_t nextState;
  logic       goodOne;

  always_comb begin
    nextState = state;
    case (state)
      ST_RESET:      nextState = ST_REF_ACQ;
      ST_REF_ACQ:    if (windowDone && inWindow) nextState = ST_REF_LOCKED;
      ST_REF_LOCKED: begin
        if (losAny)          nextState = ST_LOS_HOLD;
        else if (windowDone) nextState = inWindow ? ST_DATA_ACQ : ST_REF_ACQ;
      end
      ST_DATA_ACQ: begin
        if (losAny)                      nextState = ST_LOS_HOLD;
        else if (windowDone && !inWindow) nextState = ST_REF_ACQ;
        else if (windowDone && goodOne)   nextState = ST_DATA_LOCKED;
      end
      ST_DATA_LOCKED: begin
        if (losAny)                      nextState = ST_LOS_HOLD;
        else if (windowDone && !inWindow) nextState = ST_REF_ACQ;
      end
      ST_LOS_HOLD:   if (!losAny) nextState = ST_REF_LOCKED;
      default:       nextState = ST_RESET;
    endcase
    if (bypassEn) nextState = ST_RESET;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RESET;
      goodOne <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state)
        goodOne <= 1'b0;
      else if (state == ST_DATA_ACQ && windowDone && inWindow)
        goodOne <= 1'b1;
    end
  end

  assign trackData         = (state == ST_DATA_ACQ) || (state == ST_DATA_LOCKED);
  assign lockStatus        = (state == ST_DATA_LOCKED);
  assign strobe.winRestart = (nextState != state);
  assign strobe.muteEn     = losAny;
  assign strobe.selBypass  = bypassEn;

  // R1
  track_after_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trackData) |-> $past(state == ST_REF_LOCKED));

  // R2
  lock_two_windows_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStatus) |-> $past(goodOne && windowDone && inWindow));

  // R3
  fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (windowDone && !inWindow && trackData) |=> !trackData);

  // R5
  los_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    losAny |=> (!lockStatus && !trackData));

  // R9
  bypass_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    bypassEn |=> (!trackData && !lockStatus));

endmodule

// File: rtl/cdr_acq_top.sv
`timescale 1ns/1ps
module cdr_acq_top
  import cdr_acq_pkg::*;
#(
  parameter int unsigned WINDOW       = 65536,
  parameter int unsigned PRESCALE     = 128,
  parameter int unsigned PPM_TOL      = 500,
  parameter int unsigned MIN_TOL      = 2,
  parameter int unsigned LOS_QUIET    = 256,
  parameter int unsigned LOS_CLR_SEGS = 4,
  parameter int unsigned WORD_W       = 8
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              rateSel,
  input  logic              refFreqSel,
  input  logic              auxRefSel,
  input  logic              bypassEn,
  input  logic              extLosIn,
  input  logic              recDivClk,
  input  logic              serialSample,
  input  logic [WORD_W-1:0] rxWordIn,
  input  logic              rxWordValid,
  input  logic [WORD_W-1:0] bypWordIn,
  output logic              trackData,
  output logic              lockStatus,
  output logic [WORD_W-1:0] rxWordOut,
  output logic              rxWordOutValid
);

  acq_strobe_t strobe;
  logic        windowDone;
  logic        inWindow;
  logic        losAny;

  cdr_acq_datapath #(
    .WINDOW(WINDOW), .PRESCALE(PRESCALE), .PPM_TOL(PPM_TOL), .MIN_TOL(MIN_TOL),
    .LOS_QUIET(LOS_QUIET), .LOS_CLR_SEGS(LOS_CLR_SEGS), .SYNC_STAGES(2),
    .WORD_W(WORD_W)
  ) datapath_i (
    .clk(refClk), .rstN(rstN), .rateSel(rateSel), .refFreqSel(refFreqSel),
    .auxRefSel(auxRefSel), .recDivClk(recDivClk), .extLosIn(extLosIn),
    .serialSample(serialSample), .rxWordIn(rxWordIn), .rxWordValid(rxWordValid),
    .bypWordIn(bypWordIn), .strobe(strobe), .windowDone(windowDone),
    .inWindow(inWindow), .losAny(losAny), .rxWordOut(rxWordOut),
    .rxWordOutValid(rxWordOutValid)
  );

  cdr_acq_ctrl ctrl_i (
    .clk(refClk), .rstN(rstN), .bypassEn(bypassEn), .windowDone(windowDone),
    .inWindow(inWindow), .losAny(losAny), .strobe(strobe),
    .trackData(trackData), .lockStatus(lockStatus)
  );

endmodule

// File: tb/cdr_acq_top_tb_top.sv
`timescale 1ns/1ps
module cdr_acq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 2048;
  localparam int PRESCALE   = 128;
  localparam int LOS_QUIET  = 64;
  localparam int LOS_CLR    = 3;

  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateSel = 1'b0;
  logic       refFreqSel = 1'b1;
  logic       auxRefSel = 1'b0;
  logic       bypassEn = 1'b0;
  logic       extLosIn = 1'b0;
  logic       recDivClk = 1'b0;
  logic       serialSample = 1'b0;
  logic [7:0] rxWordIn = 8'h80;
  logic       rxWordValid = 1'b0;
  logic [7:0] bypWordIn = 8'h3C;
  logic       trackData;
  logic       lockStatus;
  logic [7:0] rxWordOut;
  logic       rxWordOutValid;

  int  nChecks = 0;
  int  nFail = 0;
  int  benchRatio = 2;
  real recErr = 0.0;
  bit  serialOn = 1'b1;
  bit  finished = 1'b0;
  int  validMismatch = 0;

  cdr_acq_top #(
    .WINDOW(WINDOW), .PRESCALE(PRESCALE), .PPM_TOL(500), .MIN_TOL(2),
    .LOS_QUIET(LOS_QUIET), .LOS_CLR_SEGS(LOS_CLR), .WORD_W(8)
  ) dut_i (
    .refClk(refClk), .rstN(rstN), .rateSel(rateSel), .refFreqSel(refFreqSel),
    .auxRefSel(auxRefSel), .bypassEn(bypassEn), .extLosIn(extLosIn),
    .recDivClk(recDivClk), .serialSample(serialSample), .rxWordIn(rxWordIn),
    .rxWordValid(rxWordValid), .bypWordIn(bypWordIn), .trackData(trackData),
    .lockStatus(lockStatus), .rxWordOut(rxWordOut), .rxWordOutValid(rxWordOutValid)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  // prescaled recovered clock: nominal while on the reference, offset while on data
  initial begin
    forever begin
      real half;
      half = (PRESCALE * CLK_PERIOD) / (2.0 * benchRatio);
      if (trackData) half = half * (1.0 + recErr);
      #(half) recDivClk = ~recDivClk;
    end
  end

  // serial line, parallel words, and output-valid tracking
  initial begin
    int  wc;
    bit  lastValid;
    wc = 0;
    lastValid = 1'b0;
    forever begin
      @(negedge refClk);
      if (rstN && (rxWordOutValid !== lastValid)) validMismatch++;
      if (serialOn) serialSample = ~serialSample;
      rxWordValid = (wc % 8) != 7;
      rxWordIn    = 8'h80 | 8'(wc & 32'h7F);
      lastValid   = rxWordValid;
      wc++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic waitTrack(input int maxCyc, output int cyc);
    cyc = 0;
    while (!trackData && cyc < maxCyc) begin @(negedge refClk); cyc++; end
  endtask

  task automatic waitLock(input int maxCyc, output int cyc);
    cyc = 0;
    while (!lockStatus && cyc < maxCyc) begin @(negedge refClk); cyc++; end
  endtask

  task automatic doReset();
    @(negedge refClk);
    rstN = 1'b0;
    cycles(4);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    int tr, tl;
    @(negedge refClk);
    rstN = 1'b0;
    cycles(3);
    check(!trackData && !lockStatus, "R1", "track/lock in reset", {trackData, lockStatus}, 0);
    check(rxWordOut == 0 && !rxWordOutValid, "R10", "word/valid in reset", rxWordOut, 0);
    rstN = 1'b1;
    waitTrack(4 * WINDOW, tr);
    check(tr > WINDOW, "R1", "data tracking not before a reference window", tr, 2 * WINDOW);
    check(tr >= 2 * WINDOW - 5 && tr <= 2 * WINDOW + 10, "R1", "cycles reset->trackData", tr, 2 * WINDOW);
    waitLock(4 * WINDOW, tl);
    check(tl >= 2 * WINDOW - 5 && tl <= 2 * WINDOW + 10, "R2", "cycles trackData->lock", tl, 2 * WINDOW);
    check(trackData && lockStatus, "R2", "locked with track high", {trackData, lockStatus}, 3);
  endtask

  task automatic testExtLos();
    int bad, tr, tl;
    extLosIn = 1'b1;
    cycles(5);
    check(!lockStatus && !trackData, "R5", "ext loss drops lock", {trackData, lockStatus}, 0);
    check(rxWordOut == 0, "R4", "word muted after ext loss", rxWordOut, 0);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge refClk);
      if (rxWordOut != 0) bad++;
    end
    check(bad == 0, "R4", "nonzero words during ext loss", bad, 0);
    check(validMismatch == 0, "R10", "valid follows during loss", validMismatch, 0);
    extLosIn = 1'b0;
    cycles(5);
    check(rxWordOut != 0, "R4", "mute released after ext loss", rxWordOut, 1);
    waitTrack(3 * WINDOW, tr);
    check(tr >= WINDOW - 5 && tr <= WINDOW + 10, "R5", "cycles loss clear->trackData", tr, WINDOW);
    waitLock(4 * WINDOW, tl);
    check(lockStatus, "R5", "relock after ext loss", lockStatus, 1);
  endtask

  task automatic testIntLos();
    int tl;
    serialOn = 1'b0;
    cycles(LOS_QUIET / 2);
    check(lockStatus, "R6", "no early internal loss", lockStatus, 1);
    cycles(LOS_QUIET / 2 + 8);
    check(!lockStatus && rxWordOut == 0, "R6", "internal loss drops lock and mutes", {lockStatus, rxWordOut}, 0);
    serialOn = 1'b1;
    cycles(100);
    check(rxWordOut == 0, "R6", "internal loss held until clean segments", rxWordOut, 0);
    cycles(LOS_CLR * LOS_QUIET + 16 - 100);
    check(rxWordOut != 0, "R6", "internal loss cleared after segments", rxWordOut, 1);
    waitLock(5 * WINDOW, tl);
    check(lockStatus, "R5", "relock after internal loss", lockStatus, 1);
  endtask

  task automatic testTolerance();
    int drops;
    recErr = 0.03;
    drops = 0;
    for (int i = 0; i < 3 * WINDOW; i++) begin
      @(negedge refClk);
      if (!lockStatus) drops++;
    end
    check(drops == 0, "R8", "lock kept with error inside band", drops, 0);
    recErr = 0.0;
  endtask

  task automatic testFallback();
    int t, seen, tl;
    recErr = 0.15;
    t = 0;
    while (lockStatus && t < 3 * WINDOW) begin @(negedge refClk); t++; end
    check(t <= 2 * WINDOW + 10, "R3", "cycles to fallback", t, WINDOW);
    check(!trackData, "R3", "track dropped with lock", trackData, 0);
    seen = 0;
    for (int i = 0; i < 4 * WINDOW; i++) begin
      @(negedge refClk);
      if (lockStatus) seen++;
    end
    check(seen == 0, "R3", "no lock while data out of band", seen, 0);
    recErr = 0.0;
    waitLock(8 * WINDOW, tl);
    check(lockStatus, "R3", "relock once error removed", lockStatus, 1);
  endtask

  task automatic testBypass();
    int tr;
    bypassEn = 1'b1;
    cycles(4);
    check(!trackData && !lockStatus, "R9", "bypass clears track/lock", {trackData, lockStatus}, 0);
    cycles(10);
    check(rxWordOut == 8'h3C, "R9", "bypass word passed", rxWordOut, 8'h3C);
    @(negedge refClk);
    bypassEn = 1'b0;
    waitTrack(4 * WINDOW, tr);
    check(tr >= 2 * WINDOW - 5 && tr <= 2 * WINDOW + 10, "R9", "restart from reference after bypass", tr, 2 * WINDOW);
    cycles(12);
    check(rxWordOut != 8'h3C && rxWordOut != 0, "R9", "normal word after bypass", rxWordOut, 8'h80);
  endtask

  task automatic testRate(input bit rs, input bit rf, input bit ax, input int ratio);
    int tl;
    rateSel = rs;
    refFreqSel = rf;
    auxRefSel = ax;
    benchRatio = ratio;
    doReset();
    waitLock(6 * WINDOW, tl);
    check(lockStatus, "R7", $sformatf("lock at ratio %0d aux=%0d", ratio, ax), lockStatus, 1);
  endtask

  initial begin
    testReset();
    testExtLos();
    testIntLos();
    testTolerance();
    testFallback();
    testBypass();
    testRate(1'b1, 1'b1, 1'b0, 8);
    testRate(1'b1, 1'b0, 1'b0, 32);
    testRate(1'b0, 1'b0, 1'b1, 2);
    testRate(1'b0, 1'b0, 1'b0, 8);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge refClk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule